// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block collects event pulses from an SD host controller core and turns them into software-visible interrupt state. There are two banks of status: one for normal events and one for error events. Each bank has two masks. The latch-enable mask decides whether an incoming pulse sets its status bit. The signal-enable mask decides whether a set status bit contributes to the interrupt line.

Software reads and writes the unit through a small synchronous register port. Status bits are cleared by writing ones to them. The normal status register also carries a read-only error summary bit. That bit reflects whether any error status bit is set while its latch-enable bit is also set. The single active-high interrupt output is registered.

Top module: `sdh_intr_ctrl`

## Requirements
- R1: After a synchronous reset, every status, latch-enable and signal-enable bit reads 0 and `irq` is 0.
- R2: A pulse on an event input sets the matching status bit only if that bit's latch-enable bit is 1. Normal event positions are:
  - command done 0, transfer done 1, block gap 2, DMA 3
  - write buffer ready 4, read buffer ready 5
  - card inserted 6, card removed 7, card interrupt 8
- R3: `irq` is 1 exactly one clock after some status bit is set while its signal-enable bit is 1. It falls one clock after that condition ends, whether the status bit is cleared or the enable is dropped.
- R4: Writing the normal status register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: The error status register (address 1) is also cleared by writing ones. Command timeout (bit 0) and data timeout (bit 4) are separate bits.
- R6: Bit 15 of the normal status register reads 1 while any error status bit is set together with its error latch-enable bit. Writing 1 to bit 15 does not clear it.
- R7: When an enabled event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The address map is:
  - 0 normal status, 1 error status
  - 2 normal latch enable, 3 error latch enable
  - 4 normal signal enable, 5 error signal enable

  Addresses 6 and 7 read 0 and writes to them have no effect. In both normal enable registers only bits 8..0 are implemented; bits 15..9 read 0.
- R9: An error status bit drives `irq` through the error signal-enable register. The summary bit 15 cannot be signal-enabled, so it never raises `irq` through the normal signal-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| norm_evt | input | 9 | Single-cycle normal event pulses |
| err_evt | input | 16 | Single-cycle error event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a collision: an enabled event pulse and a software clear landing on the same status bit in the same clock. The bench makes this happen by driving the event vector and the write strobe together on one falling edge, for both banks. It then reads the bit back.

The bench also times `irq` closely. After each enable change or clear, it samples once right after the causing edge and again one edge later, which exposes any removed or added register stage. The summary bit is driven only indirectly, through the error bank: the bench toggles the error latch-enable and the error status bits while watching bit 15.

// File: rtl/sdh_intr_pkg.sv
package sdh_intr_pkg;

    localparam int REG_W   = 16;
    localparam int NORM_W  = 9;
    localparam int ADDR_W  = 3;
    localparam int SUM_BIT = 15;

    // normal event bit positions
    localparam int EV_CMD_DONE  = 0;
    localparam int EV_XFER_DONE = 1;
    localparam int EV_BLK_GAP   = 2;
    localparam int EV_DMA       = 3;
    localparam int EV_WBUF_RDY  = 4;
    localparam int EV_RBUF_RDY  = 5;
    localparam int EV_CARD_IN   = 6;
    localparam int EV_CARD_OUT  = 7;
    localparam int EV_CARD_INT  = 8;

    // error bit positions with fixed meaning
    localparam int ER_CMD_TMO = 0;
    localparam int ER_DAT_TMO = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_NSTAT = 3'd0,
        RA_ESTAT = 3'd1,
        RA_NLEN  = 3'd2,
        RA_ELEN  = 3'd3,
        RA_NSIG  = 3'd4,
        RA_ESIG  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic clr_stat;
        logic ld_len;
        logic ld_sig;
    } bank_wr_t;

    function automatic logic [REG_W-1:0] impl_mask(input int nbits);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++)
            if (i < nbits) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sdh_intr_wdec.sv
module sdh_intr_wdec
    import sdh_intr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output bank_wr_t          nwr,
    output bank_wr_t          ewr
);

    always_comb begin
        nwr = '0;
        ewr = '0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_NSTAT: nwr.clr_stat = 1'b1;
                RA_ESTAT: ewr.clr_stat = 1'b1;
                RA_NLEN:  nwr.ld_len   = 1'b1;
                RA_ELEN:  ewr.ld_len   = 1'b1;
                RA_NSIG:  nwr.ld_sig   = 1'b1;
                RA_ESIG:  ewr.ld_sig   = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdh_intr_bank.sv
module sdh_intr_bank
    import sdh_intr_pkg::*;
#(
    parameter int             W    = REG_W,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  bank_wr_t     wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] len,
    output logic [W-1:0] sig,
    output logic         pend
);

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        set_v = evt & len;
        clr_v = wr.clr_stat ? wdata : '0;
    end

    // set has priority over clear (event wins)
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr_v) | set_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len <= '0;
            sig <= '0;
        end else begin
            if (wr.ld_len) len <= wdata & MASK;
            if (wr.ld_sig) sig <= wdata & MASK;
        end
    end

    assign pend = |(stat & sig);

    // R2: a status bit only rises when an enabled event was present
    a_r2_gated_latch: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(evt & len)) == '0));

    // R4 / R5: bits written as one without a competing event go low
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        wr.clr_stat |=> ((stat & $past(wdata & ~evt)) == '0));

    // R7: an enabled event always leaves its bit set
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~stat & $past(evt & len)) == '0));

endmodule

// File: rtl/sdh_intr_ctrl.sv
module sdh_intr_ctrl
    import sdh_intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NORM_W-1:0] norm_evt,
    input  logic [REG_W-1:0]  err_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);

    localparam logic [REG_W-1:0] N_MASK = impl_mask(NORM_W);
    localparam logic [REG_W-1:0] E_MASK = impl_mask(REG_W);

    bank_wr_t         nwr, ewr;
    logic [REG_W-1:0] n_evt_w;
    logic [REG_W-1:0] n_stat, n_len, n_sig;
    logic [REG_W-1:0] e_stat, e_len, e_sig;
    logic             n_pend, e_pend;
    logic             err_sum;
    logic             irq_q;

    assign n_evt_w = {{(REG_W-NORM_W){1'b0}}, norm_evt};

    sdh_intr_wdec u_wdec (
        .wr_en (wr_en),
        .addr  (addr),
        .nwr   (nwr),
        .ewr   (ewr)
    );

    sdh_intr_bank #(.W(REG_W), .MASK(N_MASK)) u_nbank (
        .clk   (clk),
        .rst   (rst),
        .evt   (n_evt_w),
        .wr    (nwr),
        .wdata (wr_data),
        .stat  (n_stat),
        .len   (n_len),
        .sig   (n_sig),
        .pend  (n_pend)
    );

    sdh_intr_bank #(.W(REG_W), .MASK(E_MASK)) u_ebank (
        .clk   (clk),
        .rst   (rst),
        .evt   (err_evt),
        .wr    (ewr),
        .wdata (wr_data),
        .stat  (e_stat),
        .len   (e_len),
        .sig   (e_sig),
        .pend  (e_pend)
    );

    assign err_sum = |(e_stat & e_len);

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(addr))
            RA_NSTAT: begin
                rd_data          = n_stat;
                rd_data[SUM_BIT] = err_sum;
            end
            RA_ESTAT: rd_data = e_stat;
            RA_NLEN:  rd_data = n_len;
            RA_ELEN:  rd_data = e_len;
            RA_NSIG:  rd_data = n_sig;
            RA_ESIG:  rd_data = e_sig;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= n_pend | e_pend;
    end

    assign irq = irq_q;

    // R1: interrupt is quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq);

    // R3: a raised interrupt traces back to an enabled pending bit
    a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(n_pend | e_pend));

    // R6: summary bit as read agrees with the error bank state
    a_r6_summary_view: assert property (@(posedge clk) disable iff (rst)
        (addr == RA_NSTAT) |-> (rd_data[SUM_BIT] == |(e_stat & e_len)));

    // R8: unmapped addresses read zero
    a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr > 3'd5) |-> (rd_data == '0));

endmodule

// File: tb/sdh_intr_ctrl_bench.sv
module sdh_intr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  norm_evt = '0;
    logic [15:0] err_evt  = '0;
    logic        wr_en    = 1'b0;
    logic [2:0]  addr     = '0;
    logic [15:0] wr_data  = '0;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sdh_intr_ctrl u_sdh_intr_ctrl (
        .clk      (clk),
        .rst      (rst),
        .norm_evt (norm_evt),
        .err_evt  (err_evt),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic pulse_n(input logic [8:0] m);
        @(negedge clk); norm_evt = m;
        @(posedge clk); #1; norm_evt = '0;
    endtask

    task automatic pulse_e(input logic [15:0] m);
        @(negedge clk); err_evt = m;
        @(posedge clk); #1; err_evt = '0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 6; a++) rd_chk("R1 reset value", 3'(a), 16'h0000);
        chk("R1 irq after reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_latch_gate();
        pulse_n(9'h1FF);
        rd_chk("R2 disabled events ignored", 3'd0, 16'h0000);
        wr(3'd2, 16'h00A5);
        pulse_n(9'h1FF);
        rd_chk("R2 partial latch enable", 3'd0, 16'h00A5);
        wr(3'd2, 16'h0100);
        pulse_n(9'h100);
        rd_chk("R2 card interrupt bit 8", 3'd0, 16'h01A5);
    endtask

    task automatic t_map();
        wr(3'd2, 16'hFFFF);
        rd_chk("R8 normal latch enable width", 3'd2, 16'h01FF);
        wr(3'd4, 16'hFFFF);
        rd_chk("R8 normal signal enable width", 3'd4, 16'h01FF);
        wr(3'd4, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd7, 16'hFFFF);
        rd_chk("R8 write to hole ignored", 3'd0, 16'h01A5);
        rd_chk("R8 hole 6 reads zero", 3'd6, 16'h0000);
        rd_chk("R8 hole 7 reads zero", 3'd7, 16'h0000);
    endtask

    task automatic t_w1c_norm();
        wr(3'd0, 16'h0005);
        rd_chk("R4 ones clear", 3'd0, 16'h01A0);
        wr(3'd0, 16'h0000);
        rd_chk("R4 zeros keep", 3'd0, 16'h01A0);
        wr(3'd0, 16'hFFFF);
        rd_chk("R4 clear all", 3'd0, 16'h0000);
    endtask

    task automatic t_signal();
        wr(3'd2, 16'h0002);
        pulse_n(9'h002);
        tick();
        chk("R3 no signal enable no irq", {15'd0, irq}, 16'h0000);
        wr(3'd4, 16'h0002);
        chk("R3 irq registered delay", {15'd0, irq}, 16'h0000);
        tick();
        chk("R3 irq raised", {15'd0, irq}, 16'h0001);
        wr(3'd4, 16'h0000);
        tick();
        chk("R3 irq drops on enable off", {15'd0, irq}, 16'h0000);
        wr(3'd4, 16'h0002);
        tick();
        chk("R3 irq raised again", {15'd0, irq}, 16'h0001);
        wr(3'd0, 16'h0002);
        chk("R3 irq held one cycle after clear", {15'd0, irq}, 16'h0001);
        tick();
        chk("R3 irq drops on clear", {15'd0, irq}, 16'h0000);
        wr(3'd4, 16'h0000);
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_err();
        wr(3'd3, 16'h0011);
        pulse_e(16'h0013);
        rd_chk("R5 error latch gated, timeouts separate", 3'd1, 16'h0011);
        tick();
        chk("R9 error no signal enable", {15'd0, irq}, 16'h0000);
        wr(3'd5, 16'h0010);
        tick();
        chk("R9 error data timeout irq", {15'd0, irq}, 16'h0001);
        wr(3'd1, 16'h0010);
        rd_chk("R5 error w1c", 3'd1, 16'h0001);
        tick();
        chk("R9 error irq drops", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_summary();
        rd_chk("R6 summary set", 3'd0, 16'h8000);
        wr(3'd0, 16'h8000);
        rd_chk("R6 summary not cleared by write", 3'd0, 16'h8000);
        wr(3'd4, 16'hFFFF);
        tick();
        chk("R9 summary not signal-enabled", {15'd0, irq}, 16'h0000);
        wr(3'd4, 16'h0000);
        wr(3'd3, 16'h0000);
        rd_chk("R6 summary follows error latch enable", 3'd0, 16'h0000);
        wr(3'd3, 16'h0011);
        rd_chk("R6 summary back", 3'd0, 16'h8000);
        wr(3'd1, 16'h0001);
        rd_chk("R6 summary drops after error clear", 3'd0, 16'h0000);
        rd_chk("R5 error register empty", 3'd1, 16'h0000);
    endtask

    task automatic t_collide();
        wr(3'd2, 16'h0001);
        @(negedge clk);
        norm_evt = 9'h001; wr_en = 1'b1; addr = 3'd0; wr_data = 16'h0001;
        @(posedge clk); #1;
        norm_evt = '0; wr_en = 1'b0;
        rd_chk("R7 normal event beats clear", 3'd0, 16'h0001);
        wr(3'd0, 16'h0001);
        rd_chk("R7 plain clear afterwards", 3'd0, 16'h0000);
        @(negedge clk);
        err_evt = 16'h0010; wr_en = 1'b1; addr = 3'd1; wr_data = 16'h0010;
        @(posedge clk); #1;
        err_evt = '0; wr_en = 1'b0;
        rd_chk("R7 error event beats clear", 3'd1, 16'h0010);
    endtask

    initial begin
        #20000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_latch_gate();
        t_map();
        t_w1c_norm();
        t_signal();
        t_err();
        t_summary();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule